// File: doc/BRIEF.md
# Register-Operation Decoder and ALU

This block is the execute stage of a small 8-bit accumulator machine whose instructions are 14 bits wide. Each cycle in which `issue_i` is high, it decodes the instruction word and computes a result byte. Its inputs are the accumulator, the register operand that the fetch side has already read, and the current carry flag. The instruction's top two bits pick one of four groups: literal operations (00), branch and call words (10), byte-register operations (01) and single-bit operations (11).

All outputs are registered and appear one clock after the issue. They are the result byte, a write strobe for the accumulator or for the selected register (never both), the 7-bit register select, a write strobe and a new value for each of the carry (C), nibble-carry (DC) and zero (Z) flags, and a request to skip the next instruction. Branch words, control words (including the sleep and watchdog codes) and unused encodings produce no writes, no flag updates and no skip. The surrounding core handles them.

Top module: `exu_core`

## Requirements
- R1: In byte-register operations (bits 13:12 = 01, opcode in bits 11:8, destination bit 7, register select in bits 6:0), a destination bit of 0 asserts only the accumulator strobe, and 1 asserts only the register strobe with `reg_sel_o` equal to bits 6:0. The two strobes are never asserted together.
- R2: Opcode 0101 adds register and accumulator. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is set when the 8-bit result is zero.
- R3: Opcode 1010 computes register minus accumulator. C is 1 when no borrow occurs (register >= accumulator). DC is 1 when the low nibble of the register is at least the low nibble of the accumulator. Z is set when the result is zero.
- R4: The following opcodes update Z only, from the result being zero: 0010 complement, 0011 move register, 0100 AND, 1111 OR, 1011 XOR, 1000 increment and 0110 decrement.
- R5: Opcode 1001 (increment) and opcode 0111 (decrement) change no flags. Each requests a skip exactly when its 8-bit result is zero.
- R6: Opcode 1100 rotates left and opcode 1110 rotates right, both through the carry. The bit shifted out becomes C, the old carry enters at the other end, and only C is updated.
- R7: Opcode 1101 exchanges the two nibbles and updates no flag.
- R8: Bit operations use bits 13:12 = 11, a kind in bits 11:10, a bit index in bits 9:7 and the register select in bits 6:0. Kind 11 writes the register with that bit cleared and kind 10 writes it with that bit set. Neither updates a flag or requests a skip.
- R9: Bit kind 01 requests a skip when the indexed bit is 0, and kind 00 requests a skip when it is 1. Neither writes anything nor updates a flag.
- R10: Literal operations (bits 13:12 = 00, 8-bit literal in bits 7:0) always write the accumulator. Opcode 0001 loads the literal, 1100 loads it as a return value, 0011 ORs it, 1000 XORs it and 1001 ANDs it. Only the OR, XOR and AND forms update Z.
- R11: `01 0000 1rrrrrrr` copies the accumulator to register r with no flags. `01 0001 1rrrrrrr` clears register r, and `01 0001 0000 0000` clears the accumulator. Both clears set Z to 1.
- R12: The following produce no write strobe, no flag update and no skip: branch words (bits 13:12 = 10), `01 0000 0xxxxxxx`, `01 0001 0` with a nonzero select, and literal opcodes other than those in R10.
- R13: Outputs appear on the clock edge after the issue. On reset, and on the cycle after a clock with `issue_i` low, every strobe and the skip request are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Instruction present this cycle |
| instr_i | input | 14 | Instruction word |
| acc_i | input | 8 | Accumulator value |
| reg_i | input | 8 | Selected register's value |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 8 | Result byte |
| acc_we_o | output | 1 | Write result to accumulator |
| reg_we_o | output | 1 | Write result to selected register |
| reg_sel_o | output | 7 | Register select for the write |
| c_we_o | output | 1 | Update carry flag |
| c_o | output | 1 | New carry value |
| dc_we_o | output | 1 | Update nibble-carry flag |
| dc_o | output | 1 | New nibble-carry value |
| z_we_o | output | 1 | Update zero flag |
| z_o | output | 1 | New zero value |
| skip_o | output | 1 | Skip the next instruction |

## Verification
The bench sweeps add and subtract over every register value against sixteen accumulator values. This catches a subtract carry written with borrow polarity instead of no-borrow polarity, which would invert C on every sample, and a nibble carry tapped from the wrong bit. Rotates run with both carry-in values, so a design that fills the vacated bit with zero fails half the samples. Each register value is also run through the increment and decrement skip forms, so a skip keyed to the pre-increment value fails at 255 and at 1. Every bit index is run through set, clear and both tests, so an inverted test polarity is caught. The unused literal opcodes, the control words and the branch words are issued too, and any stray write or flag strobe on these shows up as a failure.

// File: rtl/exu_pkg.sv
package exu_pkg;
    localparam int DATA_W  = 8;
    localparam int INSTR_W = 14;
    localparam int RSEL_W  = 7;
    localparam int BSEL_W  = 3;
    localparam int NIB_W   = DATA_W / 2;

    typedef enum logic [4:0] {
        K_NONE, K_ADD, K_SUB, K_AND, K_IOR, K_XOR, K_COM, K_PASS,
        K_INC, K_DEC, K_INCSZ, K_DECSZ, K_RL, K_RR, K_SWAP, K_CLR,
        K_MOVA, K_LOAD, K_BCLR, K_BSET, K_TSTCLR, K_TSTSET
    } kind_e;

    typedef struct packed {
        kind_e              kind;
        logic               use_imm;
        logic               to_acc;
        logic               to_reg;
        logic [RSEL_W-1:0]  rsel;
        logic [BSEL_W-1:0]  bsel;
        logic [DATA_W-1:0]  imm;
    } dec_t;

    typedef struct packed {
        logic we;
        logic val;
    } flag_t;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              wr_acc;
        logic              wr_reg;
        flag_t             c;
        flag_t             dc;
        flag_t             z;
        logic              skip;
    } exu_out_t;

    function automatic logic all_zero(input logic [DATA_W-1:0] v);
        return v == '0;
    endfunction
endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic [3:0] op;
    logic       dbit;

    assign op   = instr[11:8];
    assign dbit = instr[7];

    always_comb begin
        dec         = '0;
        dec.kind    = K_NONE;
        dec.rsel    = instr[RSEL_W-1:0];
        dec.bsel    = instr[9:7];
        dec.imm     = instr[DATA_W-1:0];
        case (instr[13:12])
            2'b01: begin
                case (op)
                    4'h0: if (dbit) begin
                        dec.kind   = K_MOVA;
                        dec.to_reg = 1'b1;
                    end
                    4'h1: if (dbit) begin
                        dec.kind   = K_CLR;
                        dec.to_reg = 1'b1;
                    end else if (instr[RSEL_W-1:0] == '0) begin
                        dec.kind   = K_CLR;
                        dec.to_acc = 1'b1;
                    end
                    default: begin
                        dec.to_acc = !dbit;
                        dec.to_reg = dbit;
                        case (op)
                            4'h2:    dec.kind = K_COM;
                            4'h3:    dec.kind = K_PASS;
                            4'h4:    dec.kind = K_AND;
                            4'h5:    dec.kind = K_ADD;
                            4'h6:    dec.kind = K_DEC;
                            4'h7:    dec.kind = K_DECSZ;
                            4'h8:    dec.kind = K_INC;
                            4'h9:    dec.kind = K_INCSZ;
                            4'hA:    dec.kind = K_SUB;
                            4'hB:    dec.kind = K_XOR;
                            4'hC:    dec.kind = K_RL;
                            4'hD:    dec.kind = K_SWAP;
                            4'hE:    dec.kind = K_RR;
                            default: dec.kind = K_IOR;
                        endcase
                    end
                endcase
            end
            2'b11: begin
                case (instr[11:10])
                    2'b11:   begin dec.kind = K_BCLR; dec.to_reg = 1'b1; end
                    2'b10:   begin dec.kind = K_BSET; dec.to_reg = 1'b1; end
                    2'b01:   dec.kind = K_TSTCLR;
                    default: dec.kind = K_TSTSET;
                endcase
            end
            2'b00: begin
                dec.use_imm = 1'b1;
                case (op)
                    4'h1, 4'hC: begin dec.kind = K_LOAD; dec.to_acc = 1'b1; end
                    4'h3:       begin dec.kind = K_IOR;  dec.to_acc = 1'b1; end
                    4'h8:       begin dec.kind = K_XOR;  dec.to_acc = 1'b1; end
                    4'h9:       begin dec.kind = K_AND;  dec.to_acc = 1'b1; end
                    default:    dec.use_imm = 1'b0;
                endcase
            end
            default: dec.kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
(
    input  dec_t              dec,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] regv,
    input  logic              cin,
    output exu_out_t          out
);
    logic [DATA_W-1:0] opnd;
    logic [DATA_W-1:0] mask;
    logic [DATA_W:0]   sum;
    logic [DATA_W:0]   diff;
    logic [NIB_W:0]    lsum;
    logic [NIB_W:0]    ldiff;

    assign opnd  = dec.use_imm ? dec.imm : regv;
    assign mask  = DATA_W'(1) << dec.bsel;
    assign sum   = {1'b0, opnd} + {1'b0, acc};
    assign diff  = {1'b0, opnd} - {1'b0, acc};
    assign lsum  = {1'b0, opnd[NIB_W-1:0]} + {1'b0, acc[NIB_W-1:0]};
    assign ldiff = {1'b0, opnd[NIB_W-1:0]} - {1'b0, acc[NIB_W-1:0]};

    always_comb begin
        out        = '0;
        out.wr_acc = dec.to_acc;
        out.wr_reg = dec.to_reg;
        case (dec.kind)
            K_ADD: begin
                out.res  = sum[DATA_W-1:0];
                out.c    = '{we: 1'b1, val: sum[DATA_W]};
                out.dc   = '{we: 1'b1, val: lsum[NIB_W]};
                out.z.we = 1'b1;
            end
            K_SUB: begin
                out.res  = diff[DATA_W-1:0];
                out.c    = '{we: 1'b1, val: !diff[DATA_W]};
                out.dc   = '{we: 1'b1, val: !ldiff[NIB_W]};
                out.z.we = 1'b1;
            end
            K_AND:   begin out.res = opnd & acc;  out.z.we = 1'b1; end
            K_IOR:   begin out.res = opnd | acc;  out.z.we = 1'b1; end
            K_XOR:   begin out.res = opnd ^ acc;  out.z.we = 1'b1; end
            K_COM:   begin out.res = ~opnd;       out.z.we = 1'b1; end
            K_PASS:  begin out.res = opnd;        out.z.we = 1'b1; end
            K_INC:   begin out.res = opnd + 1'b1; out.z.we = 1'b1; end
            K_DEC:   begin out.res = opnd - 1'b1; out.z.we = 1'b1; end
            K_INCSZ: begin
                out.res  = opnd + 1'b1;
                out.skip = all_zero(opnd + 1'b1);
            end
            K_DECSZ: begin
                out.res  = opnd - 1'b1;
                out.skip = all_zero(opnd - 1'b1);
            end
            K_RL: begin
                out.res = {opnd[DATA_W-2:0], cin};
                out.c   = '{we: 1'b1, val: opnd[DATA_W-1]};
            end
            K_RR: begin
                out.res = {cin, opnd[DATA_W-1:1]};
                out.c   = '{we: 1'b1, val: opnd[0]};
            end
            K_SWAP:   out.res = {opnd[NIB_W-1:0], opnd[DATA_W-1:NIB_W]};
            K_CLR:    begin out.res = '0; out.z.we = 1'b1; end
            K_MOVA:   out.res = acc;
            K_LOAD:   out.res = opnd;
            K_BCLR:   out.res = opnd & ~mask;
            K_BSET:   out.res = opnd | mask;
            K_TSTCLR: out.skip = (opnd & mask) == '0;
            K_TSTSET: out.skip = (opnd & mask) != '0;
            default:  out.res = '0;
        endcase
        out.z.val = all_zero(out.res);
    end
endmodule

// File: rtl/exu_core.sv
module exu_core
    import exu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               issue_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [DATA_W-1:0]  acc_i,
    input  logic [DATA_W-1:0]  reg_i,
    input  logic               carry_i,
    output logic [DATA_W-1:0]  result_o,
    output logic               acc_we_o,
    output logic               reg_we_o,
    output logic [RSEL_W-1:0]  reg_sel_o,
    output logic               c_we_o,
    output logic               c_o,
    output logic               dc_we_o,
    output logic               dc_o,
    output logic               z_we_o,
    output logic               z_o,
    output logic               skip_o
);
    dec_t              dec;
    exu_out_t          alu_out;
    exu_out_t          out_q;
    logic [RSEL_W-1:0] sel_q;

    exu_decode u_decode (
        .instr (instr_i),
        .dec   (dec)
    );

    exu_alu u_alu (
        .dec  (dec),
        .acc  (acc_i),
        .regv (reg_i),
        .cin  (carry_i),
        .out  (alu_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            sel_q <= '0;
        end else if (issue_i) begin
            out_q <= alu_out;
            sel_q <= dec.rsel;
        end else begin
            out_q <= '0;
            sel_q <= '0;
        end
    end

    assign result_o  = out_q.res;
    assign acc_we_o  = out_q.wr_acc;
    assign reg_we_o  = out_q.wr_reg;
    assign reg_sel_o = sel_q;
    assign c_we_o    = out_q.c.we;
    assign c_o       = out_q.c.val;
    assign dc_we_o   = out_q.dc.we;
    assign dc_o      = out_q.dc.val;
    assign z_we_o    = out_q.z.we;
    assign z_o       = out_q.z.val;
    assign skip_o    = out_q.skip;

    // R1
    one_dest_chk: assert property (@(posedge clk) disable iff (rst)
        !(acc_we_o && reg_we_o));

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !issue_i |=> !(acc_we_o || reg_we_o || skip_o || c_we_o || dc_we_o || z_we_o));

    // R2
    dc_with_arith_chk: assert property (@(posedge clk) disable iff (rst)
        dc_we_o |-> (c_we_o && z_we_o));

    // R5
    skip_no_flags_chk: assert property (@(posedge clk) disable iff (rst)
        skip_o |-> !(c_we_o || dc_we_o || z_we_o));

    // R6
    rotate_c_only_chk: assert property (@(posedge clk) disable iff (rst)
        (c_we_o && !dc_we_o) |-> !z_we_o);

    // R4
    zero_matches_chk: assert property (@(posedge clk) disable iff (rst)
        z_we_o |-> (z_o == (result_o == '0)));
endmodule

// File: tb/exu_core_bench.sv
module exu_core_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_i = 1'b0;
    logic [13:0] instr_i = '0;
    logic [7:0]  acc_i = '0;
    logic [7:0]  reg_i = '0;
    logic        carry_i = 1'b0;
    logic [7:0]  result_o;
    logic        acc_we_o, reg_we_o;
    logic [6:0]  reg_sel_o;
    logic        c_we_o, c_o, dc_we_o, dc_o, z_we_o, z_o, skip_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    exu_core u_exu_core (
        .clk(clk), .rst(rst), .issue_i(issue_i), .instr_i(instr_i),
        .acc_i(acc_i), .reg_i(reg_i), .carry_i(carry_i),
        .result_o(result_o), .acc_we_o(acc_we_o), .reg_we_o(reg_we_o),
        .reg_sel_o(reg_sel_o), .c_we_o(c_we_o), .c_o(c_o),
        .dc_we_o(dc_we_o), .dc_o(dc_o), .z_we_o(z_we_o), .z_o(z_o),
        .skip_o(skip_o)
    );

    function automatic logic [13:0] rform(input int op, input bit d, input int sel);
        return {2'b01, 4'(op), d, 7'(sel)};
    endfunction

    task automatic run(input logic [13:0] ins, input int a, input int r, input bit cin);
        issue_i = 1'b1;
        instr_i = ins;
        acc_i   = 8'(a);
        reg_i   = 8'(r);
        carry_i = cin;
        @(posedge clk);
        @(negedge clk);
        issue_i = 1'b0;
    endtask

    task automatic expect_out(input string rq, input int er, input bit ea, input bit ew,
                              input int esel, input bit ecw, input bit ec, input bit edw,
                              input bit edc, input bit ezw, input bit ez, input bit esk);
        bit bad;
        bad = 0;
        if (acc_we_o !== ea || reg_we_o !== ew || c_we_o !== ecw || dc_we_o !== edw ||
            z_we_o !== ezw || skip_o !== esk) bad = 1;
        if ((ea || ew) && result_o !== 8'(er)) bad = 1;
        if (ew && reg_sel_o !== 7'(esel)) bad = 1;
        if (ecw && c_o !== ec) bad = 1;
        if (edw && dc_o !== edc) bad = 1;
        if (ezw && z_o !== ez) bad = 1;
        n_chk++;
        if (bad) begin
            n_bad++;
            $display("FAIL %s instr=%h: act res=%h aw=%b rw=%b sel=%h cw=%b c=%b dw=%b dc=%b zw=%b z=%b sk=%b | exp res=%h aw=%b rw=%b sel=%h cw=%b c=%b dw=%b dc=%b zw=%b z=%b sk=%b",
                     rq, instr_i, result_o, acc_we_o, reg_we_o, reg_sel_o, c_we_o, c_o,
                     dc_we_o, dc_o, z_we_o, z_o, skip_o,
                     8'(er), ea, ew, 7'(esel), ecw, ec, edw, edc, ezw, ez, esk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int res, sel;
        bit d;
        repeat (3) @(negedge clk);
        // R13: reset state
        expect_out("R13", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        rst = 1'b0;
        @(negedge clk);
        expect_out("R13", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // R1 R2: add sweep
        for (int r = 0; r < 256; r++) begin
            for (int a = 0; a < 256; a += 17) begin
                d = r[0]; sel = (r * 5) % 128;
                res = (r + a) % 256;
                run(rform(5, d, sel), a, r, 0);
                expect_out("R2", res, !d, d, sel, 1, (r + a) > 255, 1,
                           (r % 16 + a % 16) > 15, 1, res == 0, 0);
            end
        end

        // R1 R3: subtract sweep
        for (int r = 0; r < 256; r++) begin
            for (int a = 0; a < 256; a += 17) begin
                d = r[1]; sel = r % 128;
                res = (r - a + 256) % 256;
                run(rform(10, d, sel), a, r, 1);
                expect_out("R3", res, !d, d, sel, 1, r >= a, 1,
                           (r % 16) >= (a % 16), 1, res == 0, 0);
            end
        end

        // R4: Z-only operations
        for (int k = 0; k < 7; k++) begin
            int ops[7] = '{2, 3, 4, 6, 8, 11, 15};
            for (int r = 0; r < 256; r++) begin
                int a;
                a = (r * 37 + 11) % 256;
                case (ops[k])
                    2:  res = 255 - r;
                    3:  res = r;
                    4:  res = r & a;
                    6:  res = (r + 255) % 256;
                    8:  res = (r + 1) % 256;
                    11: res = r ^ a;
                    default: res = r | a;
                endcase
                d = r[0];
                run(rform(ops[k], d, r % 128), a, r, 1);
                expect_out("R4", res, !d, d, r % 128, 0, 0, 0, 0, 1, res == 0, 0);
            end
        end

        // R5: increment/decrement with skip
        for (int r = 0; r < 256; r++) begin
            d = r[2];
            res = (r + 1) % 256;
            run(rform(9, d, 3), 0, r, 0);
            expect_out("R5", res, !d, d, 3, 0, 0, 0, 0, 0, 0, res == 0);
            res = (r + 255) % 256;
            run(rform(7, d, 4), 0, r, 0);
            expect_out("R5", res, !d, d, 4, 0, 0, 0, 0, 0, 0, res == 0);
        end

        // R6: rotates through carry
        for (int r = 0; r < 256; r++) begin
            for (int c = 0; c < 2; c++) begin
                d = r[0];
                res = ((r * 2) + c) % 256;
                run(rform(12, d, 9), 0, r, c[0]);
                expect_out("R6", res, !d, d, 9, 1, r >= 128, 0, 0, 0, 0, 0);
                res = (c * 128) + (r / 2);
                run(rform(14, d, 9), 0, r, c[0]);
                expect_out("R6", res, !d, d, 9, 1, (r % 2) == 1, 0, 0, 0, 0, 0);
            end
        end

        // R7: nibble swap
        for (int r = 0; r < 256; r++) begin
            d = r[3];
            res = (r % 16) * 16 + r / 16;
            run(rform(13, d, 100), 0, r, 1);
            expect_out("R7", res, !d, d, 100, 0, 0, 0, 0, 0, 0, 0);
        end

        // R8 R9: bit operations
        for (int b = 0; b < 8; b++) begin
            for (int v = 0; v < 8; v++) begin
                int r;
                bit bitv;
                r = (v * 73 + b * 29) % 256;
                bitv = ((r >> b) % 2) == 1;
                run({2'b11, 2'b11, 3'(b), 7'(v + 20)}, 0, r, 0);
                expect_out("R8", r & (255 - (1 << b)), 0, 1, v + 20, 0, 0, 0, 0, 0, 0, 0);
                run({2'b11, 2'b10, 3'(b), 7'(v + 20)}, 0, r, 0);
                expect_out("R8", r | (1 << b), 0, 1, v + 20, 0, 0, 0, 0, 0, 0, 0);
                run({2'b11, 2'b01, 3'(b), 7'(v)}, 0, r, 0);
                expect_out("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, !bitv);
                run({2'b11, 2'b00, 3'(b), 7'(v)}, 0, r, 0);
                expect_out("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, bitv);
            end
        end

        // R10: literal operations
        for (int i = 0; i < 256; i++) begin
            int a;
            a = (i * 11 + 90) % 256;
            run({2'b00, 4'h1, 8'(i)}, a, 0, 0);
            expect_out("R10", i, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
            run({2'b00, 4'hC, 8'(i)}, a, 0, 0);
            expect_out("R10", i, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
            run({2'b00, 4'h3, 8'(i)}, a, 0, 0);
            expect_out("R10", i | a, 1, 0, 0, 0, 0, 0, 0, 1, (i | a) == 0, 0);
            run({2'b00, 4'h8, 8'(i)}, a, 0, 0);
            expect_out("R10", i ^ a, 1, 0, 0, 0, 0, 0, 0, 1, (i ^ a) == 0, 0);
            run({2'b00, 4'h9, 8'(i)}, a, 0, 0);
            expect_out("R10", i & a, 1, 0, 0, 0, 0, 0, 0, 1, (i & a) == 0, 0);
        end

        // R11: accumulator store and clears
        for (int s = 0; s < 128; s += 9) begin
            run({2'b01, 4'h0, 1'b1, 7'(s)}, s * 2 + 1, 77, 0);
            expect_out("R11", s * 2 + 1, 0, 1, s, 0, 0, 0, 0, 0, 0, 0);
            run({2'b01, 4'h1, 1'b1, 7'(s)}, 55, 200, 0);
            expect_out("R11", 0, 0, 1, s, 0, 0, 0, 0, 1, 1, 0);
        end
        run(14'b01_0001_0000_0000, 99, 99, 0);
        expect_out("R11", 0, 1, 0, 0, 0, 0, 0, 0, 1, 1, 0);

        // R12: unrecognised and control encodings
        for (int s = 0; s < 128; s += 13) begin
            run({2'b01, 4'h0, 1'b0, 7'(s)}, 0, 0, 0);
            expect_out("R12", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
            run({2'b10, 12'(s * 31)}, 0, 0, 0);
            expect_out("R12", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
            if (s != 0) begin
                run({2'b01, 4'h1, 1'b0, 7'(s)}, 0, 0, 0);
                expect_out("R12", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
            end
        end
        for (int o = 0; o < 16; o++) begin
            if (o != 1 && o != 3 && o != 8 && o != 9 && o != 12) begin
                run({2'b00, 4'(o), 8'h00}, 0, 0, 0);
                expect_out("R12", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
            end
        end

        // R13: idle after issue clears strobes
        run(rform(5, 1, 5), 255, 1, 0);
        expect_out("R13", 0, 0, 1, 5, 1, 1, 1, 1, 1, 1, 0);
        @(negedge clk);
        expect_out("R13", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule